// File: doc/BRIEF.md
# Interleaved Multi-Queue Byte Feeder

This block holds several independent packets in small on-chip byte queues, one packet per queue at a time. Each cycle it hands a single byte to a downstream matching pipeline. The source queue changes every cycle in a fixed rotation, so bytes that sit next to each other in the pipeline always belong to different packets and never depend on each other. Each issued byte travels with the index of its queue and with flags that mark the first and last byte of its packet.

A writer loads bytes into a queue that it picks by index. It flags the final byte of a packet, and a per-queue ready signal tells it whether the queue will accept more. When a queue is empty in its turn, the slot goes out as a bubble and the rotation still moves on. The downstream logic can flush a queue when it has reached a verdict on that queue's packet. A flush discards what is left of the packet and frees the queue for the next packet. The depth of each queue is the total byte budget divided by the number of queues.

Top module: `mq_byte_feeder`

## Requirements
- R1: While reset is held, out_valid is 0 and every bit of wr_ready is 1. The first clock edge after reset is released issues the slot of queue 0, so out_queue is 0 in the following cycle.
- R2: The slot index advances by one each clock, wrapping from NUM_QUEUES-1 to 0. out_queue shows the slot of the previous cycle, whether or not a byte was issued.
- R3: A byte is issued only in its own queue's slot, one cycle after that slot. Bytes of one queue come out in the order they were accepted. A byte accepted at a clock edge can be issued at the earliest on a later edge.
- R4: When the slot's queue is empty, or that queue is flushed in the same cycle, the cycle after shows out_valid = 0.
- R5: out_start is 1 only on the first accepted byte of a packet. out_end is 1 only on a byte that was written with wr_last = 1. Both are 0 whenever out_valid is 0.
- R6: A queue holds DEPTH = TOTAL_BYTES / NUM_QUEUES bytes. With DEPTH bytes stored its wr_ready is 0, and a write offered while wr_ready is 0 is not stored.
- R7: Once a byte with wr_last = 1 is accepted, that queue's wr_ready stays 0 until that end byte has been issued or the queue is flushed.
- R8: A flush of a queue whose packet is complete discards every byte still stored. In the next cycle wr_ready is 1 and no byte of that packet is ever issued.
- R9: A flush of a queue whose packet is still arriving discards the stored bytes. Later writes to that queue are accepted (wr_ready = 1) and dropped, up to and including the next byte with wr_last = 1. The byte after that starts a new packet. A write to the flushed queue in the flush cycle is dropped too, and if it carries wr_last it closes the dropped packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A byte is offered for writing |
| wr_queue | input | QIW | Index of the target queue |
| wr_data | input | DATA_W | Byte value offered |
| wr_last | input | 1 | Offered byte is the last of its packet |
| wr_ready | output | NUM_QUEUES | Per-queue acceptance indication |
| flush | input | NUM_QUEUES | Per-queue request to drop the rest of the packet |
| out_valid | output | 1 | Issued slot carries a byte |
| out_queue | output | QIW | Queue index of the issued slot |
| out_data | output | DATA_W | Issued byte |
| out_start | output | 1 | Issued byte opens its packet |
| out_end | output | 1 | Issued byte closes its packet |

## Verification
The bench builds the block with three queues and a 24-byte budget, so each queue is eight bytes deep. A count of three is not a power of two, which selects the compare-and-wrap rotation variant. The shallow depth lets queues fill within a few writes, which makes the refusal path and a full queue racing against its own drain slot common events. Directed packets cover a completed packet, a full queue and flushes both before and after the last byte. Random traffic with sparse end markers and rare flushes then mixes these states across queues.

// File: rtl/mqf_pkg.sv
package mqf_pkg;

   typedef enum logic [1:0] {
      QM_OPEN   = 2'd0,
      QM_CLOSED = 2'd1,
      QM_DROP   = 2'd2
   } qmode_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mqf_rotor.sv
module mqf_rotor #(
   parameter int NUM = 4,
   parameter int W   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] slot
);
   localparam logic [W-1:0] LAST = W'(NUM - 1);

   logic [W-1:0] slot_q;
   logic         armed;

   generate
      if (mqf_pkg::is_pow2(NUM)) begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)             slot_q <= '0;
            else if (slot_q == LAST) slot_q <= '0;
            else                    slot_q <= slot_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign slot = slot_q;

   p_slot_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + 1'b1));

   p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= LAST);

endmodule

// File: rtl/mqf_queue.sv
module mqf_queue
   import mqf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   input  logic              rd_en,
   input  logic              flush,
   output logic              ready,
   output logic              nonempty,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_start,
   output logic              rd_end
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     head, tail, count;
   logic [AW-1:0]     start_ptr, end_ptr;
   qmode_t            mode;
   logic              started, start_pending;
   logic              full, drop_next;

   assign count    = tail - head;
   assign full     = (count == FULL_CNT);
   assign nonempty = (head != tail);
   assign ready    = (mode == QM_DROP) || ((mode == QM_OPEN) && !full);
   assign rd_data  = mem[head[AW-1:0]];
   assign rd_start = start_pending && (head[AW-1:0] == start_ptr);
   assign rd_end   = (mode == QM_CLOSED) && (head[AW-1:0] == end_ptr);

   // after a flush the queue drops input until the packet's last byte is seen
   assign drop_next = ((mode == QM_DROP) ||
                       ((mode == QM_OPEN) && (started || wr_en))) &&
                      !(wr_en && wr_last);

   always_ff @(posedge clk) begin
      if (wr_en && !flush && (mode != QM_DROP))
         mem[tail[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head          <= '0;
         tail          <= '0;
         start_ptr     <= '0;
         end_ptr       <= '0;
         mode          <= QM_OPEN;
         started       <= 1'b0;
         start_pending <= 1'b0;
      end else if (flush) begin
         head          <= tail;
         started       <= 1'b0;
         start_pending <= 1'b0;
         mode          <= drop_next ? QM_DROP : QM_OPEN;
      end else begin
         if (rd_en) begin
            head <= head + 1'b1;
            if (rd_start) start_pending <= 1'b0;
            if (rd_end) begin
               mode    <= QM_OPEN;
               started <= 1'b0;
            end
         end
         if (wr_en) begin
            if (mode == QM_DROP) begin
               if (wr_last) mode <= QM_OPEN;
            end else begin
               tail <= tail + 1'b1;
               if (!started) begin
                  started       <= 1'b1;
                  start_pending <= 1'b1;
                  start_ptr     <= tail[AW-1:0];
               end
               if (wr_last) begin
                  mode    <= QM_CLOSED;
                  end_ptr <= tail[AW-1:0];
               end
            end
         end
      end
   end

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (mode == QM_OPEN)) |-> !full);

   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && (mode == QM_OPEN)) |=> nonempty);

   p_closed_refuses_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == QM_CLOSED) && !flush) |=> $stable(tail));

   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !nonempty);

   p_drop_discards_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == QM_DROP) |=> $stable(tail));

endmodule

// File: rtl/mq_byte_feeder.sv
module mq_byte_feeder #(
   parameter int NUM_QUEUES  = 4,
   parameter int TOTAL_BYTES = 64,
   parameter int DATA_W      = 8,
   parameter int QIW         = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [QIW-1:0]        wr_queue,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  wr_last,
   output logic [NUM_QUEUES-1:0] wr_ready,
   input  logic [NUM_QUEUES-1:0] flush,
   output logic                  out_valid,
   output logic [QIW-1:0]        out_queue,
   output logic [DATA_W-1:0]     out_data,
   output logic                  out_start,
   output logic                  out_end
);
   localparam int DEPTH = TOTAL_BYTES / NUM_QUEUES;

   generate
      if (NUM_QUEUES < 2) begin : g_bad_count
         $error("mq_byte_feeder: NUM_QUEUES must be at least 2");
      end
      if ((TOTAL_BYTES % NUM_QUEUES) != 0) begin : g_bad_split
         $error("mq_byte_feeder: TOTAL_BYTES must divide evenly by NUM_QUEUES");
      end
      if (!mqf_pkg::is_pow2(DEPTH) || (DEPTH < 2)) begin : g_bad_depth
         $error("mq_byte_feeder: per-queue depth must be a power of two >= 2");
      end
      if (QIW < $clog2(NUM_QUEUES)) begin : g_bad_idx
         $error("mq_byte_feeder: QIW too narrow for NUM_QUEUES");
      end
   endgenerate

   logic [QIW-1:0]        slot;
   logic [NUM_QUEUES-1:0] q_ready, q_nonempty, q_start, q_end, rd_en, wr_en;
   logic [DATA_W-1:0]     q_data [NUM_QUEUES];

   logic                  issue, sel_start, sel_end;
   logic [DATA_W-1:0]     sel_data;

   mqf_rotor #(.NUM(NUM_QUEUES), .W(QIW)) u_rotor (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   generate
      for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
         assign wr_en[g] = wr_valid && (wr_queue == QIW'(g)) && q_ready[g];
         assign rd_en[g] = (slot == QIW'(g)) && q_nonempty[g] && !flush[g];

         mqf_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_data  (wr_data),
            .wr_last  (wr_last),
            .rd_en    (rd_en[g]),
            .flush    (flush[g]),
            .ready    (q_ready[g]),
            .nonempty (q_nonempty[g]),
            .rd_data  (q_data[g]),
            .rd_start (q_start[g]),
            .rd_end   (q_end[g])
         );
      end
   endgenerate

   assign wr_ready = q_ready;

   always_comb begin
      issue     = 1'b0;
      sel_data  = '0;
      sel_start = 1'b0;
      sel_end   = 1'b0;
      for (int i = 0; i < NUM_QUEUES; i++) begin
         if (rd_en[i]) begin
            issue     = 1'b1;
            sel_data  = q_data[i];
            sel_start = q_start[i];
            sel_end   = q_end[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_queue <= '0;
         out_data  <= '0;
         out_start <= 1'b0;
         out_end   <= 1'b0;
      end else begin
         out_valid <= issue;
         out_queue <= slot;
         out_data  <= sel_data;
         out_start <= sel_start;
         out_end   <= sel_end;
      end
   end

   p_one_reader_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_en));

   p_bubble_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(out_start || out_end));

   p_flushed_slot_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush[slot] || !q_nonempty[slot]) |=> !out_valid);

endmodule

// File: tb/mq_byte_feeder_test.sv
module mq_byte_feeder_test;
   localparam int NQ    = 3;
   localparam int TOT   = 24;
   localparam int DEPTH = TOT / NQ;
   localparam int QIW   = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           rst_n;
   logic           wr_valid;
   logic [QIW-1:0] wr_queue;
   logic [7:0]     wr_data;
   logic           wr_last;
   logic [NQ-1:0]  wr_ready;
   logic [NQ-1:0]  flush;
   logic           out_valid;
   logic [QIW-1:0] out_queue;
   logic [7:0]     out_data;
   logic           out_start;
   logic           out_end;

   mq_byte_feeder #(.NUM_QUEUES(NQ), .TOTAL_BYTES(TOT), .DATA_W(8), .QIW(QIW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_queue(wr_queue),
      .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready), .flush(flush),
      .out_valid(out_valid), .out_queue(out_queue), .out_data(out_data),
      .out_start(out_start), .out_end(out_end)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model of the queues
   logic [7:0] md [NQ][DEPTH];
   bit         ms [NQ][DEPTH];
   bit         me [NQ][DEPTH];
   int         mh [NQ];
   int         mc [NQ];
   bit         mclosed [NQ];
   bit         mstarted [NQ];
   bit         mdrop [NQ];
   int         mslot;

   bit         ev, es, ee;
   int         eq;
   logic [7:0] ed;

   function automatic bit mready(input int q);
      return mdrop[q] || (!mclosed[q] && (mc[q] < DEPTH));
   endfunction

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int q = 0; q < NQ; q++) begin
         mh[q] = 0; mc[q] = 0;
         mclosed[q] = 0; mstarted[q] = 0; mdrop[q] = 0;
      end
      mslot = 0;
   endtask

   task automatic model_edge();
      int  s;
      int  idx;
      bit  acc;
      bit  w;
      bit  nd;
      s   = mslot;
      acc = wr_valid && (int'(wr_queue) < NQ) && mready(int'(wr_queue));
      ev  = (mc[s] > 0) && !flush[s];
      eq  = s; ed = 8'h00; es = 0; ee = 0;
      if (ev) begin
         ed = md[s][mh[s]]; es = ms[s][mh[s]]; ee = me[s][mh[s]];
         mh[s] = (mh[s] + 1) % DEPTH;
         mc[s]--;
         if (ee) begin mclosed[s] = 0; mstarted[s] = 0; end
      end
      for (int q = 0; q < NQ; q++) begin
         w = acc && (int'(wr_queue) == q);
         if (flush[q]) begin
            nd = (mdrop[q] || (!mclosed[q] && (mstarted[q] || w))) && !(w && wr_last);
            mc[q] = 0; mh[q] = 0;
            mclosed[q] = 0; mstarted[q] = 0; mdrop[q] = nd;
         end else if (w) begin
            if (mdrop[q]) begin
               if (wr_last) mdrop[q] = 0;
            end else begin
               idx = (mh[q] + mc[q]) % DEPTH;
               md[q][idx] = wr_data;
               ms[q][idx] = !mstarted[q];
               me[q][idx] = wr_last;
               mc[q]++;
               mstarted[q] = 1;
               if (wr_last) mclosed[q] = 1;
            end
         end
      end
      mslot = (mslot + 1) % NQ;
   endtask

   task automatic step(input bit wv, input int wq, input logic [7:0] wd,
                       input bit wl, input logic [NQ-1:0] fl);
      wr_valid = wv; wr_queue = QIW'(wq); wr_data = wd; wr_last = wl; flush = fl;
      #1;
      for (int q = 0; q < NQ; q++)
         chk("R6/R7/R8/R9 wr_ready", wr_ready[q] == mready(q), wr_ready[q], mready(q));
      model_edge();
      @(posedge clk);
      #1;
      chk("R4 out_valid", out_valid == ev, out_valid, ev);
      chk("R2 out_queue", int'(out_queue) == eq, out_queue, eq);
      if (ev) begin
         chk("R3 out_data", out_data == ed, out_data, ed);
         chk("R5 out_start", out_start == es, out_start, es);
         chk("R5 out_end", out_end == ee, out_end, ee);
      end else begin
         chk("R5 bubble flags", !out_start && !out_end, {out_start, out_end}, 0);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, '0);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      rst_n = 0; wr_valid = 0; wr_queue = '0; wr_data = '0; wr_last = 0; flush = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset out_valid", out_valid == 0, out_valid, 0);
      chk("R1 reset wr_ready", wr_ready == '1, wr_ready, (1 << NQ) - 1);
      rst_n = 1;
      model_reset();
      step(0, 0, 8'h00, 0, '0);
      chk("R1 first slot", out_queue == 0, out_queue, 0);

      // complete packet in queue 0
      step(1, 0, 8'h11, 0, '0);
      step(1, 0, 8'h22, 0, '0);
      step(1, 0, 8'h33, 1, '0);
      chk("R7 closed after last", wr_ready[0] == 0, wr_ready[0], 0);
      step(1, 0, 8'h44, 0, '0);
      idle(9);
      chk("R7 reopened after end issued", wr_ready[0] == 1, wr_ready[0], 1);

      // overfill queue 1
      for (int i = 0; i < 16; i++) step(1, 1, 8'(8'h80 + i), 0, '0);
      chk("R6 full refusal", wr_ready[1] == mready(1), wr_ready[1], mready(1));
      step(1, 1, 8'hF0, 1, '0);
      idle(30);

      // flush mid-packet on queue 2
      step(1, 2, 8'hA1, 0, '0);
      step(1, 2, 8'hA2, 0, '0);
      step(0, 0, 8'h00, 0, 3'b100);
      chk("R9 drop mode ready", wr_ready[2] == 1, wr_ready[2], 1);
      step(1, 2, 8'hA3, 0, '0);
      step(1, 2, 8'hA4, 1, '0);
      step(1, 2, 8'hB1, 1, '0);
      idle(6);

      // flush of a completed packet on queue 0
      step(1, 0, 8'hC1, 0, '0);
      step(1, 0, 8'hC2, 0, '0);
      step(1, 0, 8'hC3, 0, '0);
      step(1, 0, 8'hC4, 1, '0);
      step(0, 0, 8'h00, 0, 3'b001);
      chk("R8 ready after flush", wr_ready[0] == 1, wr_ready[0], 1);
      idle(6);

      // flush with a concurrent last-byte write
      step(1, 1, 8'hD1, 0, '0);
      step(1, 1, 8'hD2, 1, 3'b010);
      chk("R9 same-cycle last closes drop", wr_ready[1] == mready(1), wr_ready[1], mready(1));
      idle(6);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [NQ-1:0] fl;
         for (int q = 0; q < NQ; q++) fl[q] = (($urandom % 40) == 0);
         step(($urandom % 10) < 7, $urandom % NQ, 8'($urandom), ($urandom % 6) == 0, fl);
      end
      idle(40);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule